// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block sits between an internal bus master and an external memory bus and decides whether a number of dead (idle) bus states must pass before the next external access may begin. It remembers three facts about the last access that actually started: its area number, its direction (read or write), and whether it was a DMA single-address transfer. When the master raises a request, the block compares the new access against that record. A 16-bit control register selects which access pairs count as conflicts and how many idle states a conflict costs.

The master holds its request, together with the area, direction and single-address attributes, until it sees the grant. During idle states the grant stays low. On the cycle the access may begin, the block raises both the grant to the master and a start strobe to the external bus. The control register also carries a write-data-buffer enable bit, which is brought out unchanged for the write path that lies outside this block.

Top module: `bus_idle_inserter`

## Requirements
- R1: The control register is 16 bits wide and resets to 0. A register write stores all 16 bits, including the reserved ones, and the read port returns the stored value.
- R2: Output `wbuf_en` follows control bit 8 (1 = write-data buffer in use).
- R3: The first access after reset never gets idle states. Grant and start assert in the same cycle as the request, whatever the mode.
- R4: Mode field (control bits 3:2) value 00 inserts no idle states for any pair of accesses.
- R5: Mode 01 inserts idle states when a read follows a read to a different area. It inserts none for two reads to the same area, and none for two writes to different areas.
- R6: Modes 01 and above insert idle states before any access that follows a single-address transfer.
- R7: Modes 10 and 11 also insert idle states when a write follows a read. Mode 01 does not.
- R8: Mode 11 also inserts idle states when a read follows a write. Modes 01 and 10 do not.
- R9: Length field (control bits 1:0) code k gives k+1 idle states. The request cycle counts as the first idle state, so grant asserts exactly k+1 cycles after the request was first seen.
- R10: Grant is low during every idle state. Grant and start assert together, for exactly one cycle per access.
- R11: The record of the previous access changes only when an access starts. A request withdrawn during its idle states leaves the record unchanged.
- R12: A register write made during an idle sequence does not change the length of that sequence. The new setting applies from the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request from the master, held until grant |
| req_area | input | AREA_W | Area number of the requested access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sat | input | 1 | 1 = access is a DMA single-address transfer |
| gnt | output | 1 | Grant to the master; high in the cycle the access starts |
| acc_start | output | 1 | Access-start strobe to the external bus |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data |
| wbuf_en | output | 1 | Write-data-buffer enable (control bit 8) |

## Verification
On every cycle, the assertions check several properties. Grant stays low while idle states run. The idle counter never sits at zero inside an idle sequence and loses exactly one per cycle. The previous-access record holds still whenever no access starts. Mode 00, and any request with no record, is granted at once. The conflict policy itself is shown only by the bench's scenarios: area change, single-address follow-on, write-after-read and read-after-write, each against each mode. The bench scenarios also cover the idle count for every length code, a request withdrawn mid-sequence, and a register rewrite during an idle sequence.

// File: rtl/bii_pkg.sv
package bii_pkg;

  localparam int unsigned CFG_W      = 16;
  localparam int unsigned LEN_W      = 2;
  localparam int unsigned LEN_LSB    = 0;
  localparam int unsigned MODE_LSB   = 2;
  localparam int unsigned WBUF_BIT   = 8;

  typedef enum logic [1:0] {
    POL_OFF       = 2'b00,
    POL_AREA_SAT  = 2'b01,
    POL_PLUS_WAR  = 2'b10,
    POL_PLUS_RAW  = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'b00,
    SEQ_IDLE = 2'b01,
    SEQ_GO   = 2'b10
  } seq_state_e;

endpackage

// File: rtl/bii_cfg_reg.sv
module bii_cfg_reg
  import bii_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R1

endmodule

// File: rtl/bii_history.sv
module bii_history #(
  parameter int unsigned AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AREA_W-1:0] cur_area,
  input  logic              cur_write,
  input  logic              cur_sat,
  output logic              prev_valid,
  output logic [AREA_W-1:0] prev_area,
  output logic              prev_write,
  output logic              prev_sat
);

  logic              valid_d;
  logic [AREA_W-1:0] area_d;
  logic              write_d;
  logic              sat_d;

  always_comb begin
    valid_d = prev_valid;
    area_d  = prev_area;
    write_d = prev_write;
    sat_d   = prev_sat;
    if (start) begin
      valid_d = 1'b1;
      area_d  = cur_area;
      write_d = cur_write;
      sat_d   = cur_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_area  <= '0;
      prev_write <= 1'b0;
      prev_sat   <= 1'b0;
    end else begin
      prev_valid <= valid_d;
      prev_area  <= area_d;
      prev_write <= write_d;
      prev_sat   <= sat_d;
    end
  end

  AST_RECORD_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(prev_area) && $stable(prev_write) && $stable(prev_sat) && $stable(prev_valid))); // R11

endmodule

// File: rtl/bii_policy.sv
module bii_policy
  import bii_pkg::*;
#(
  parameter int unsigned AREA_W = 3
) (
  input  policy_e           mode,
  input  logic              prev_valid,
  input  logic [AREA_W-1:0] prev_area,
  input  logic              prev_write,
  input  logic              prev_sat,
  input  logic [AREA_W-1:0] cur_area,
  input  logic              cur_write,
  output logic              need_idle
);

  logic area_change;
  logic after_sat;
  logic wr_after_rd;
  logic rd_after_wr;
  logic hit;

  always_comb begin
    area_change = !prev_write && !cur_write && (prev_area != cur_area);
    after_sat   = prev_sat;
    wr_after_rd = !prev_write && cur_write;
    rd_after_wr = prev_write && !cur_write;
    unique case (mode)
      POL_OFF:      hit = 1'b0;
      POL_AREA_SAT: hit = area_change || after_sat;
      POL_PLUS_WAR: hit = area_change || after_sat || wr_after_rd;
      POL_PLUS_RAW: hit = area_change || after_sat || wr_after_rd || rd_after_wr;
      default:      hit = 1'b0;
    endcase
    need_idle = prev_valid && hit;
  end

endmodule

// File: rtl/bii_sequencer.sv
module bii_sequencer
  import bii_pkg::*;
#(
  parameter int unsigned CNT_W = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             need_idle,
  input  logic             prev_valid,
  input  logic [CNT_W-1:0] len_code,
  output logic             gnt,
  output logic             ready,
  output logic             idling
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gnt     = 1'b0;
    idling  = 1'b0;
    ready   = (state_q == SEQ_RUN);
    unique case (state_q)
      SEQ_RUN: begin
        if (req) begin
          if (need_idle) begin
            idling = 1'b1;
            cnt_d  = len_code;
            state_d = (len_code == '0) ? SEQ_GO : SEQ_IDLE;
          end else begin
            gnt = 1'b1;
          end
        end
      end
      SEQ_IDLE: begin
        idling = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) state_d = SEQ_GO;
      end
      SEQ_GO: begin
        gnt     = req;
        state_d = SEQ_RUN;
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_NO_GNT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> !gnt); // R10

  AST_IDLE_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> (cnt_q != '0)); // R9

  AST_IDLE_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R12

  AST_FIRST_ACCESS_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_RUN) && req && !prev_valid) |-> gnt); // R3

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> req); // R10

endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import bii_pkg::*;
#(
  parameter int unsigned AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_sat,
  output logic              gnt,
  output logic              acc_start,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              wbuf_en
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  logic [CFG_W-1:0]  cfg_q;
  policy_e           mode;
  logic [LEN_W-1:0]  len_code;
  logic              prev_valid;
  logic [AREA_W-1:0] prev_area;
  logic              prev_write;
  logic              prev_sat;
  logic              need_idle;
  logic              seq_gnt;
  logic              seq_ready;
  logic              seq_idling;

  bii_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  assign mode      = policy_e'(cfg_q[MODE_LSB +: 2]);
  assign len_code  = cfg_q[LEN_LSB +: LEN_W];
  assign wbuf_en   = cfg_q[WBUF_BIT];
  assign cfg_rdata = cfg_q;

  bii_history #(.AREA_W(AREA_W)) u_hist (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start      (seq_gnt),
    .cur_area   (req_area),
    .cur_write  (req_write),
    .cur_sat    (req_sat),
    .prev_valid (prev_valid),
    .prev_area  (prev_area),
    .prev_write (prev_write),
    .prev_sat   (prev_sat)
  );

  bii_policy #(.AREA_W(AREA_W)) u_pol (
    .mode       (mode),
    .prev_valid (prev_valid),
    .prev_area  (prev_area),
    .prev_write (prev_write),
    .prev_sat   (prev_sat),
    .cur_area   (req_area),
    .cur_write  (req_write),
    .need_idle  (need_idle)
  );

  bii_sequencer #(.CNT_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .req        (req),
    .need_idle  (need_idle),
    .prev_valid (prev_valid),
    .len_code   (len_code),
    .gnt        (seq_gnt),
    .ready      (seq_ready),
    .idling     (seq_idling)
  );

  assign gnt       = seq_gnt;
  assign acc_start = seq_gnt;

  AST_MODE_OFF_NO_IDLE: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((mode == POL_OFF) && req && seq_ready) |-> gnt); // R4

  AST_IDLE_BLOCKS_START: assert property (@(posedge clk) disable iff (!core_rst_n)
    seq_idling |-> !acc_start); // R10

  AST_WBUF_TRACKS_CFG: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cfg_we && cfg_wdata[WBUF_BIT]) |=> wbuf_en); // R2

endmodule

// File: tb/bus_idle_inserter_test.sv
`timescale 1ns/1ps
module bus_idle_inserter_test;

  localparam int AREA_W = 3;
  localparam int NVEC   = 12;

  logic              clk;
  logic              rst_n;
  logic              req;
  logic [AREA_W-1:0] req_area;
  logic              req_write;
  logic              req_sat;
  logic              gnt;
  logic              acc_start;
  logic              cfg_we;
  logic [15:0]       cfg_wdata;
  logic [15:0]       cfg_rdata;
  logic              wbuf_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bus_idle_inserter #(.AREA_W(AREA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_area(req_area),
    .req_write(req_write), .req_sat(req_sat), .gnt(gnt), .acc_start(acc_start),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wbuf_en(wbuf_en)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // fields: mode[16:15] len[14:13] a_area[12:10] a_wr[9] a_sat[8]
  //         b_area[7:5] b_wr[4] b_sat[3] expected idle states of b [2:0]
  localparam logic [16:0] VEC [NVEC] = '{
    {2'd0, 2'd3, 3'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 3'd0}, // R4 rd/rd area change, off
    {2'd1, 2'd0, 3'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 3'd1}, // R5 rd/rd area change
    {2'd1, 2'd1, 3'd1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 3'd0}, // R5 same area
    {2'd1, 2'd3, 3'd2, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 3'd0}, // R5 wr/wr area change
    {2'd1, 2'd2, 3'd1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd3}, // R6 after single-address
    {2'd1, 2'd0, 3'd1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 3'd0}, // R7 war not in mode 01
    {2'd2, 2'd1, 3'd1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 3'd2}, // R7 war in mode 10
    {2'd2, 2'd0, 3'd1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 3'd0}, // R8 raw not in mode 10
    {2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 3'd4}, // R8 raw in mode 11
    {2'd3, 2'd0, 3'd1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 3'd1}, // R7 war in mode 11
    {2'd2, 2'd3, 3'd0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 3'd4}, // R9 longest idle
    {2'd0, 2'd3, 3'd4, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 3'd0}  // R4 after sat, off
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns number of cycles with grant low while request was held
  task automatic access(input logic [AREA_W-1:0] a, input bit wr, input bit sat,
                        output int waits);
    @(negedge clk);
    req = 1'b1; req_area = a; req_write = wr; req_sat = sat;
    waits = 0;
    #1;
    while (!gnt && waits < 20) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(posedge clk);
    #1;
    req = 1'b0;
  endtask

  initial begin
    int w;
    logic [16:0] v;
    rst_n = 0; req = 0; req_area = '0; req_write = 0; req_sat = 0;
    cfg_we = 0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check(cfg_rdata == 16'h0000, "R1 reset value", cfg_rdata, 0);
    check(wbuf_en == 1'b0, "R2 reset wbuf_en", wbuf_en, 0);
    check(gnt == 1'b0 && acc_start == 1'b0, "R10 no grant at reset", gnt, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R3: first access after reset, most aggressive setting
    cfg_write(16'h000F);
    access(3'd1, 1'b1, 1'b1, w);
    check(w == 0, "R3 first access", w, 0);

    // R1/R2: full-width storage including reserved bits
    cfg_write(16'hA5F0);
    #1;
    check(cfg_rdata == 16'hA5F0, "R1 readback", cfg_rdata, 16'hA5F0);
    check(wbuf_en == 1'b1, "R2 wbuf_en set", wbuf_en, 1);
    cfg_write(16'h5A0F);
    #1;
    check(cfg_rdata == 16'h5A0F, "R1 readback 2", cfg_rdata, 16'h5A0F);
    check(wbuf_en == 1'b0, "R2 wbuf_en clear", wbuf_en, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      cfg_write({12'h000, v[16:15], v[14:13]});
      access(v[12:10], v[9], v[8], w);
      access(v[7:5], v[4], v[3], w);
      check(w == int'(v[2:0]), $sformatf("vector %0d (R4-R9 table)", i), w, v[2:0]);
    end

    // R10: strobe is a single cycle aligned with grant
    cfg_write(16'h0004);
    access(3'd1, 1'b0, 1'b0, w);
    @(negedge clk);
    req = 1'b1; req_area = 3'd2; req_write = 1'b0; req_sat = 1'b0;
    #1;
    check(gnt == 1'b0 && acc_start == 1'b0, "R10 low in idle state", acc_start, 0);
    @(negedge clk); #1;
    check(gnt == 1'b1 && acc_start == 1'b1, "R10 start with grant", acc_start, 1);
    @(posedge clk); #1;
    req = 1'b0;
    @(negedge clk); #1;
    check(acc_start == 1'b0, "R10 one-cycle strobe", acc_start, 0);

    // R11: withdrawn request leaves the record unchanged
    cfg_write(16'h0007);
    access(3'd1, 1'b0, 1'b0, w);
    @(negedge clk);
    req = 1'b1; req_area = 3'd6; req_write = 1'b0; req_sat = 1'b0;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    access(3'd1, 1'b0, 1'b0, w);
    check(w == 0, "R11 record kept after withdraw", w, 0);
    access(3'd6, 1'b0, 1'b0, w);
    check(w == 4, "R11 record still live", w, 4);

    // R12: length rewrite during idle sequence does not shorten it
    cfg_write(16'h0007);
    access(3'd1, 1'b0, 1'b0, w);
    @(negedge clk);
    req = 1'b1; req_area = 3'd2; req_write = 1'b0; req_sat = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 16'h0004;
    w = 0;
    #1;
    while (!gnt && w < 20) begin
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      w++;
    end
    @(posedge clk); #1;
    req = 1'b0;
    check(w == 4, "R12 running sequence kept", w, 4);
    access(3'd3, 1'b0, 1'b0, w);
    check(w == 1, "R12 new length next decision", w, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule